// File: doc/BRIEF.md
# Five-Port Mesh Router with X-then-Y Routing

This block is one switching node of a two-dimensional mesh. It has five ports: local processor, north, south, east and west. Each port has an input queue and an output. A flit that arrives on any input is held in that input's queue. When the flit reaches the head of the queue, per-input route logic compares the flit's destination coordinates with the node's own coordinates, given on `node_x`/`node_y`. The route logic picks one output, and it always corrects the X difference before the Y difference.

Each output has its own round-robin scheduler. In each cycle the scheduler picks one of the heads that want that output and switches it through to that output. Flow control is valid/ready with no credits. A queue gives up its head only in the cycle in which that head is granted and the downstream side is ready. A head that cannot leave therefore holds back every flit queued behind it.

A flit whose chosen output is the port it came in on is a U-turn. The router reports it on `uturn_drop` and discards it.

Top module: `mesh_router`

## Requirements
- R1: Port indices are 0 local, 1 north, 2 south, 3 east, 4 west. A flit packs destination X in bits [COORD_W-1:0], destination Y in the next COORD_W bits, and payload above those. Let dx = dest X − node X. If dx < 0 the flit leaves on port 4 (west). If dx > 0 it leaves on port 3 (east). The Y coordinate does not affect either case.
- R2: If dx = 0, then with dy = dest Y − node Y the flit leaves on port 2 (south) when dy < 0 and on port 1 (north) when dy > 0.
- R3: If dx = 0 and dy = 0, the flit leaves on port 0 (local).
- R4: Offsets are signed and one bit wider than the coordinate fields. The direction is therefore correct even at the extremes, for example node X = 0 with dest X = 2^COORD_W − 1, and the reverse.
- R5: Each output serves the competing heads in round-robin order. After reset, input 0 has top priority. After a completed transfer from input w, top priority moves to input w+1 (wrapping). A grant whose output is not ready leaves the priority unchanged.
- R6: A queue head that cannot leave blocks every later flit in the same queue, even flits bound for idle outputs. Queues stay first-in first-out.
- R7: `in_ready` of an input is low exactly while its queue holds DEPTH flits. A flit offered while `in_ready` is low is not taken.
- R8: When a head's computed output equals its arrival port, `uturn_drop` for that input is high in that cycle. The flit appears on no output and is removed at the next clock edge. This includes a local-input flit addressed to the node itself.
- R9: During and right after a synchronous active-low reset, all queues are empty, every `in_ready` is high, and every `out_valid` and `uturn_drop` is low.
- R10: Route choice and grant are combinational from the queue head. Consider a flit accepted at a clock edge into an empty queue whose output is uncontested. It is presented on that output in the cycle that follows that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_x | input | COORD_W | X coordinate of this node |
| node_y | input | COORD_W | Y coordinate of this node |
| in_flit | input | 5*FLIT_W | Flit on each input, port p at bits [p*FLIT_W +: FLIT_W] |
| in_valid | input | 5 | Input flit offered, one bit per port |
| in_ready | output | 5 | Input queue can accept a flit |
| out_flit | output | 5*FLIT_W | Flit on each output, same packing as in_flit |
| out_valid | output | 5 | Output flit present |
| out_ready | input | 5 | Downstream side accepts the output flit |
| uturn_drop | output | 5 | Head of that input is a U-turn being discarded |

## Verification
Every result of this block is due in the cycle after the clock edge that changed the queue state. A flit taken at an edge appears on its output, or on `uturn_drop`, right after that edge. A completed transfer or drop removes the head, and moves the round-robin priority, at the next edge. The bench drives its inputs at the falling edge and compares all outputs 1 ns later against a behavioural model of queues and priority pointers. The model's state is updated once per rising edge with the same pop, push and priority rules, so each expected value refers to exactly the cycle in which the design must present it. Directed phases cover each direction, including the coordinate extremes, contention at one output, a stalled head, a full queue and U-turns. A long randomized phase follows them.

// File: rtl/mesh_router_pkg.sv
// Shared port numbering for the mesh router.
// Assumes exactly five ports; the index order is fixed because the route
// logic and the U-turn check compare a direction with an input index.
package mesh_router_pkg;
    localparam int NPORT = 5;

    typedef enum logic [2:0] {
        DIR_LOCAL = 3'd0,
        DIR_NORTH = 3'd1,
        DIR_SOUTH = 3'd2,
        DIR_EAST  = 3'd3,
        DIR_WEST  = 3'd4
    } dir_e;
endpackage

// File: rtl/mesh_in_fifo.sv
// Per-input flit queue.
// Does: stores up to DEPTH flits in order and shows the oldest on dout.
// Assumes: DEPTH >= 2; push while full and pop while empty are ignored.
module mesh_in_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         nonempty
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    slots [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CNTW-1:0] fill;
    logic            do_push;
    logic            do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (fill == CNTW'(DEPTH));
    assign nonempty = (fill != '0);
    assign dout     = slots[rd_ptr];
    assign do_push  = push & ~full;
    assign do_pop   = pop & nonempty;

    // Write the incoming flit into the slot at the tail.
    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= din;
    end

    // Advance head/tail pointers and the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R7: the fill level never exceeds the depth.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNTW'(DEPTH));

    // R6: a head that is not removed stays put (blocking what follows).
    a_r6_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (nonempty && !pop) |=> (nonempty && $stable(dout)));
endmodule

// File: rtl/mesh_route.sv
// Dimension-order route computation for one input.
// Does: picks the output from signed X then Y offsets to this node.
// Assumes: coordinates are unsigned; purely combinational.
module mesh_route
    import mesh_router_pkg::*;
#(
    parameter int COORD_W = 3
) (
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    output dir_e               dir
);
    logic signed [COORD_W:0] off_x;
    logic signed [COORD_W:0] off_y;

    // Offsets one bit wider than the fields so the sign is never lost.
    assign off_x = {1'b0, dest_x} - {1'b0, here_x};
    assign off_y = {1'b0, dest_y} - {1'b0, here_y};

    // Correct X first, then Y, then deliver locally.
    always_comb begin
        if (off_x < 0)      dir = DIR_WEST;
        else if (off_x > 0) dir = DIR_EAST;
        else if (off_y < 0) dir = DIR_SOUTH;
        else if (off_y > 0) dir = DIR_NORTH;
        else                dir = DIR_LOCAL;
    end
endmodule

// File: rtl/mesh_rr_arb.sv
// Round-robin scheduler for one output.
// Does: grants the first requester at or after the priority pointer.
// Assumes: advance is high only in a cycle where the grant was consumed.
module mesh_rr_arb #(
    parameter int N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    input  logic              advance,
    output logic [N-1:0]      gnt,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] prio;

    // Scan from the priority pointer, wrapping, and take the first request.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = int'(prio) + k;
            if (idx >= N) idx = idx - N;
            if (req[idx]) begin
                gnt     = '0;
                gnt[idx] = 1'b1;
                gnt_idx = IW'(idx);
            end
        end
    end

    // Move priority just past the winner after a completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio <= '0;
        end else if (advance && (|gnt)) begin
            prio <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
        end
    end

    // R5: at most one input granted per output per cycle.
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R5: priority stays put unless a transfer completed.
    a_r5_prio_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && (|gnt)) |=> $stable(prio));
endmodule

// File: rtl/mesh_router.sv
// Five-port input-queued mesh router, X-then-Y routing.
// Does: queues each input, routes its head, schedules each output
// round-robin, switches the winner through and drops U-turns.
// Assumes: single-flit packets; valid/ready on every edge, no credits.
module mesh_router
    import mesh_router_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int PAY_W   = 8,
    parameter int DEPTH   = 4,
    localparam int FLIT_W = PAY_W + 2 * COORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [COORD_W-1:0]        node_x,
    input  logic [COORD_W-1:0]        node_y,
    input  logic [5*FLIT_W-1:0]       in_flit,
    input  logic [4:0]                in_valid,
    output logic [4:0]                in_ready,
    output logic [5*FLIT_W-1:0]       out_flit,
    output logic [4:0]                out_valid,
    input  logic [4:0]                out_ready,
    output logic [4:0]                uturn_drop
);
    localparam int IW = $clog2(NPORT);

    logic [FLIT_W-1:0] head      [NPORT];
    dir_e              head_dir  [NPORT];
    logic [NPORT-1:0]  head_vld;
    logic [NPORT-1:0]  q_full;
    logic [NPORT-1:0]  q_pop;
    logic [NPORT-1:0]  sent_from;
    logic [NPORT-1:0]  want      [NPORT];
    logic [NPORT-1:0]  gnt       [NPORT];
    logic [IW-1:0]     gnt_idx   [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        mesh_in_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (in_valid[p]),
            .din      (in_flit[p*FLIT_W +: FLIT_W]),
            .pop      (q_pop[p]),
            .dout     (head[p]),
            .full     (q_full[p]),
            .nonempty (head_vld[p])
        );

        mesh_route #(.COORD_W(COORD_W)) u_rt (
            .here_x (node_x),
            .here_y (node_y),
            .dest_x (head[p][COORD_W-1:0]),
            .dest_y (head[p][2*COORD_W-1:COORD_W]),
            .dir    (head_dir[p])
        );

        assign in_ready[p]   = ~q_full[p];
        assign uturn_drop[p] = head_vld[p] && (head_dir[p] == dir_e'(p));
        assign q_pop[p]      = uturn_drop[p] | sent_from[p];

        // R8: a dropped U-turn head is never switched to an output.
        a_r8_drop_not_sent: assert property (@(posedge clk) disable iff (!rst_n)
            uturn_drop[p] |-> !sent_from[p]);
    end

    // Build each output's request vector from the routed heads.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                want[o][i] = head_vld[i] && (head_dir[i] == dir_e'(o)) && (o != i);
            end
        end
    end

    // Note which inputs complete a transfer this cycle.
    always_comb begin
        sent_from = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (gnt[o][i] && out_ready[o]) sent_from[i] = 1'b1;
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        mesh_rr_arb #(.N(NPORT)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (want[o]),
            .advance (out_ready[o]),
            .gnt     (gnt[o]),
            .gnt_idx (gnt_idx[o])
        );

        assign out_valid[o]                 = |gnt[o];
        assign out_flit[o*FLIT_W +: FLIT_W] = head[gnt_idx[o]];
    end
endmodule

// File: tb/tb_mesh_router.sv
module tb_mesh_router;
    localparam int CW = 3;
    localparam int PW = 8;
    localparam int D  = 4;
    localparam int N  = 5;
    localparam int FW = PW + 2 * CW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   node_x = '0;
    logic [CW-1:0]   node_y = '0;
    logic [N*FW-1:0] in_flit = '0;
    logic [N-1:0]    in_valid = '0;
    logic [N-1:0]    in_ready;
    logic [N*FW-1:0] out_flit;
    logic [N-1:0]    out_valid;
    logic [N-1:0]    out_ready = '1;
    logic [N-1:0]    uturn_drop;

    always #5 clk = ~clk;

    mesh_router #(.COORD_W(CW), .PAY_W(PW), .DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
        .in_flit(in_flit), .in_valid(in_valid), .in_ready(in_ready),
        .out_flit(out_flit), .out_valid(out_valid), .out_ready(out_ready),
        .uturn_drop(uturn_drop)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 1'b0;
    string tag   = "R9";
    logic [FW-1:0] mq [N][$];
    int    mprio [N];

    function automatic logic [FW-1:0] mk(int x, int y, int pay);
        logic [FW-1:0] f;
        f = {pay[PW-1:0], y[CW-1:0], x[CW-1:0]};
        return f;
    endfunction

    // Expected output per R1..R4, from full-range integer offsets.
    function automatic int dir_of(logic [FW-1:0] f);
        int dx, dy;
        dx = int'(f[CW-1:0]) - int'(node_x);
        dy = int'(f[2*CW-1:CW]) - int'(node_y);
        if (dx < 0) return 4;
        if (dx > 0) return 3;
        if (dy < 0) return 2;
        if (dy > 0) return 1;
        return 0;
    endfunction

    task automatic check(string t, string what, int p, logic [FW-1:0] act, logic [FW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s port %0d cycle %0d actual=%h expected=%h", t, what, p, cyc, act, exp);
        end
    endtask

    // Compare this cycle against the model, then advance the model one edge.
    task automatic step();
        bit rdy [N];
        bit drop [N];
        bit pop [N];
        int win [N];
        #1;
        for (int i = 0; i < N; i++) begin
            rdy[i]  = mq[i].size() < D;
            drop[i] = (mq[i].size() > 0) && (dir_of(mq[i][0]) == i);
            pop[i]  = drop[i];
            check("R7", "in_ready", i, FW'(in_ready[i]), FW'(rdy[i]));
            check("R8", "uturn_drop", i, FW'(uturn_drop[i]), FW'(drop[i]));
        end
        for (int o = 0; o < N; o++) begin
            win[o] = -1;
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = (mprio[o] + k) % N;
                if (win[o] < 0 && idx != o && mq[idx].size() > 0 && dir_of(mq[idx][0]) == o)
                    win[o] = idx;
            end
            check(tag, "out_valid", o, FW'(out_valid[o]), FW'(win[o] >= 0));
            if (win[o] >= 0)
                check(tag, "out_flit", o, out_flit[o*FW +: FW], mq[win[o]][0]);
        end
        for (int o = 0; o < N; o++) begin
            if (win[o] >= 0 && out_ready[o]) begin
                pop[win[o]] = 1'b1;
                mprio[o] = (win[o] + 1) % N;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (pop[i]) void'(mq[i].pop_front());
            if (in_valid[i] && rdy[i]) mq[i].push_back(in_flit[i*FW +: FW]);
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(int n);
        in_valid  = '0;
        out_ready = '1;
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic offer(int p, logic [FW-1:0] f);
        in_valid[p] = 1'b1;
        in_flit[p*FW +: FW] = f;
    endtask

    initial begin
        int pay;
        pay = 0;
        for (int i = 0; i < N; i++) mprio[i] = 0;
        // R9: state held in reset.
        repeat (3) @(negedge clk);
        for (int p = 0; p < N; p++) begin
            check("R9", "reset out_valid", p, FW'(out_valid[p]), '0);
            check("R9", "reset in_ready", p, FW'(in_ready[p]), FW'(1));
            check("R9", "reset uturn_drop", p, FW'(uturn_drop[p]), '0);
        end
        rst_n = 1'b1;
        tag = "R9";
        idle(2);

        // R1 R2 R3 R4 R10: every destination from three node positions.
        tag = "R1 R2 R3 R4 R10";
        for (int s = 0; s < 3; s++) begin
            node_x = (s == 0) ? 3'd3 : (s == 1) ? 3'd0 : 3'd7;
            node_y = (s == 0) ? 3'd3 : (s == 1) ? 3'd7 : 3'd0;
            for (int x = 0; x < 8; x++) begin
                for (int y = 0; y < 8; y++) begin
                    in_valid = '0;
                    offer(1 + ((x + y) % 4), mk(x, y, pay++));
                    step();
                end
            end
            idle(4);
        end

        // R5: four inputs contend for the local output.
        tag = "R5";
        node_x = 3'd3; node_y = 3'd3;
        for (int k = 0; k < 30; k++) begin
            for (int p = 1; p < N; p++) offer(p, mk(3, 3, pay++));
            out_ready[0] = (k % 3) != 2;
            step();
        end
        idle(20);

        // R6 R7: east is stalled; west input's later local flits are stuck.
        tag = "R6 R7";
        out_ready = '1;
        out_ready[3] = 1'b0;
        offer(4, mk(5, 3, pay++));
        step();
        for (int k = 0; k < 8; k++) begin
            offer(4, mk(3, 3, pay++));
            offer(1, mk(3, 3, pay++));
            step();
        end
        in_valid = '0;
        for (int k = 0; k < 3; k++) step();
        out_ready[3] = 1'b1;
        idle(12);

        // R8: U-turns on east, south and local inputs.
        tag = "R8";
        for (int k = 0; k < 3; k++) begin
            in_valid = '0;
            offer(3, mk(6, 1, pay++));
            offer(2, mk(3, 0, pay++));
            offer(0, mk(3, 3, pay++));
            step();
        end
        idle(6);

        // All requirements: randomized traffic and back-pressure.
        tag = "R1 R2 R3 R4 R5 R6 R10";
        for (int blk = 0; blk < 4; blk++) begin
            node_x = CW'($urandom_range(0, 7));
            node_y = CW'($urandom_range(0, 7));
            for (int k = 0; k < 500; k++) begin
                for (int p = 0; p < N; p++) begin
                    in_valid[p]  = ($urandom_range(0, 99) < 45);
                    in_flit[p*FW +: FW] = FW'($urandom);
                    out_ready[p] = ($urandom_range(0, 99) < 70);
                end
                step();
            end
            idle(30);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R9 run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule